// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides a 32-bit dividend by a 32-bit divisor over many clock cycles, one quotient bit per cycle. It yields a 32-bit quotient on `lo` and a 32-bit remainder on `hi`. A request is raised with a one-cycle `start` pulse while the block is idle. The block then holds `busy` high for the whole run and pulses `done` for one cycle when `hi` and `lo` carry the new result. Both outputs keep that result until the next run completes.

The datapath is restoring. A double-width remainder register is loaded with the dividend magnitude. A double-width divisor register is loaded with the divisor magnitude in its upper half. In each step the divisor register is subtracted from the remainder register. A non-negative difference is kept and a 1 is shifted into the quotient. A negative difference leaves the remainder as it was and shifts in a 0. The divisor register then moves right by one bit. There are 33 steps. With `signed_mode` high, the operands are treated as two's complement and their magnitudes are divided. After the last step the signs are corrected: the quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. A zero divisor still runs to completion and returns a defined result.

Top module: `seq_restoring_divider`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `hi` and `lo` are all 0.
- R2: `start` is accepted only while `busy` is low. A `start` raised while `busy` is high is ignored: it produces no extra `done` pulse and does not change the result of the run in progress.
- R3: When `start` is sampled high at a clock edge while idle, `busy` is high from the next cycle on. At the 34th edge after the accepting edge, `busy` falls and `done` rises, and `done` stays high for exactly one cycle.
- R4: With `signed_mode` = 0 and a nonzero divisor, `lo` = floor(dividend / divisor) and `hi` = dividend mod divisor, both operands taken as unsigned.
- R5: With `signed_mode` = 1 and a nonzero divisor, `lo` is the two's complement quotient truncated toward zero. It is negative exactly when the operand signs differ and its magnitude is nonzero.
- R6: With `signed_mode` = 1 and a nonzero divisor, a nonzero `hi` has the sign of the dividend and a magnitude below that of the divisor, so that lo*divisor + hi = dividend.
- R7: With a zero divisor, in either mode, the run completes in the normal time with `lo` = 0xFFFFFFFF and `hi` equal to the dividend bits as given.
- R8: With `signed_mode` = 1, dividend 0x80000000 and divisor 0xFFFFFFFF (-1), the result wraps: `lo` = 0x80000000 and `hi` = 0.
- R9: `hi` and `lo` change only in the cycle `done` rises. They hold their values while idle and throughout a following run.
- R10: A `start` raised in the cycle in which `done` is high is accepted and begins a new run with the new operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; operands and mode are sampled with it |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | 32 | Dividend, sampled with an accepted `start` |
| divisor | input | 32 | Divisor, sampled with an accepted `start` |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse marking a fresh result on `hi`/`lo` |
| hi | output | 32 | Remainder |
| lo | output | 32 | Quotient |

## Verification
Completion and acceptance can fall in the same cycle. While `done` is high the block is already idle, so a new `start` there must be taken, and the result being reported must not be disturbed by it. The bench waits for the `done` cycle of one run and raises `start` with different operands in that same cycle. The scoreboard then expects the first result unchanged, a second `done` exactly 34 edges later carrying the second operands' result, and `hi`/`lo` frozen in between. A `start` pulse raised in the middle of a run with unrelated operands is judged the same way: it must leave the queued result intact and must not add a `done` pulse.

// File: rtl/div_pkg.sv
// Package: shared types for the sequential restoring divider.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package div_pkg;

    // Controller phases: waiting, iterating, publishing the result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;

endpackage

// File: rtl/div_operand_prep.sv
// Module: div_operand_prep
// Turns raw operands into magnitudes and sign-correction flags.
// Assumes: purely combinational; the caller samples the outputs on load.
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_raw,
    input  logic [W-1:0] b_raw,
    input  logic         signed_mode,
    output logic [W-1:0] a_mag,
    output logic [W-1:0] b_mag,
    output logic         q_neg,
    output logic         r_neg,
    output logic         b_zero
);

    logic a_is_neg;
    logic b_is_neg;

    // Sign detection applies only when the operands are two's complement.
    always_comb begin
        a_is_neg = signed_mode & a_raw[W-1];
        b_is_neg = signed_mode & b_raw[W-1];
    end

    // Magnitudes: negate negative operands; the most negative value maps to 2^(W-1).
    always_comb begin
        a_mag = a_is_neg ? (~a_raw + W'(1)) : a_raw;
        b_mag = b_is_neg ? (~b_raw + W'(1)) : b_raw;
    end

    // Correction flags used after the last iteration.
    always_comb begin
        q_neg  = a_is_neg ^ b_is_neg;
        r_neg  = a_is_neg;
        b_zero = (b_raw == '0);
    end

    // R5: a magnitude never has its top bit set unless it is the most negative value.
    always_comb begin
        if (a_is_neg && a_raw != {1'b1, {(W-1){1'b0}}}) begin
            a_r5_mag_positive: assert (a_mag[W-1] == 1'b0);
        end
    end

endmodule

// File: rtl/div_ctrl.sv
// Module: div_ctrl
// Sequences one division: a load cycle, W+1 iteration cycles and one publish cycle.
// Assumes: start is ignored outside the idle phase.
module div_ctrl
    import div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy
);

    localparam int ITER = W + 1;
    localparam int CW   = $clog2(ITER);

    div_state_t    state;
    logic [CW-1:0] cnt;

    // Phase register and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt == CW'(ITER - 1)) begin
                        state <= ST_FIN;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobes derived from the phase.
    always_comb begin
        load   = (state == ST_IDLE) && start;
        step   = (state == ST_RUN);
        finish = (state == ST_FIN);
        busy   = (state != ST_IDLE);
    end

    // R3: the publish cycle is always preceded by an iteration cycle.
    a_r3_fin_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> $past(step));

    // R3: publishing lasts one cycle and returns to idle.
    a_r3_fin_single: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (!finish && !busy));

    // R2: an accepted start begins iterating from the first count.
    a_r2_load_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (step && cnt == '0));

    // R3: the counter never passes the last iteration.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt <= CW'(ITER - 1)));

endmodule

// File: rtl/div_step_core.sv
// Module: div_step_core
// Restoring magnitude datapath: one trial subtraction and one quotient bit per step.
// Assumes: load and step are never high together; operands are magnitudes.
module div_step_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic         finish,
    input  logic [W-1:0] dividend_mag,
    input  logic [W-1:0] divisor_mag,
    output logic [W-1:0] quot_mag,
    output logic [W-1:0] rem_mag
);

    localparam int DW = 2 * W;

    logic [DW-1:0] rem_q;
    logic [DW-1:0] dvs_q;
    logic [W-1:0]  quo_q;
    logic [DW:0]   trial;
    logic          trial_neg;
    logic [W-1:0]  chk_dividend;
    logic [W-1:0]  chk_divisor;

    // Trial subtraction with one guard bit to expose the sign.
    always_comb begin
        trial     = {1'b0, rem_q} - {1'b0, dvs_q};
        trial_neg = trial[DW];
    end

    // Remainder, divisor and quotient registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            dvs_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= {{W{1'b0}}, dividend_mag};
            dvs_q <= {divisor_mag, {W{1'b0}}};
            quo_q <= '0;
        end else if (step) begin
            if (!trial_neg) begin
                rem_q <= trial[DW-1:0];
            end
            quo_q <= {quo_q[W-2:0], ~trial_neg};
            dvs_q <= {1'b0, dvs_q[DW-1:1]};
        end
    end

    // Copies of the loaded operands, kept only for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_dividend <= '0;
            chk_divisor  <= '0;
        end else if (load) begin
            chk_dividend <= dividend_mag;
            chk_divisor  <= divisor_mag;
        end
    end

    // Magnitude results.
    always_comb begin
        quot_mag = quo_q;
        rem_mag  = rem_q[W-1:0];
    end

    // R4: magnitudes satisfy quotient*divisor + remainder = dividend.
    a_r4_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && chk_divisor != '0) |->
        (DW'(quo_q) * DW'(chk_divisor) + rem_q == DW'(chk_dividend)));

    // R6: the magnitude remainder is below the divisor.
    a_r6_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && chk_divisor != '0) |-> (rem_q[W-1:0] < chk_divisor));

    // R4: the remainder never grows past single width.
    a_r4_rem_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (rem_q[DW-1:W] == '0));

endmodule

// File: rtl/div_sign_fix.sv
// Module: div_sign_fix
// Holds the sign flags of a run and publishes corrected results on finish.
// Assumes: flags arrive with load; magnitudes are final in the finish cycle.
module div_sign_fix #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         finish,
    input  logic [W-1:0] a_raw,
    input  logic         signed_mode,
    input  logic         q_neg,
    input  logic         r_neg,
    input  logic         b_zero,
    input  logic [W-1:0] quot_mag,
    input  logic [W-1:0] rem_mag,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo,
    output logic         done
);

    logic [W-1:0] a_hold;
    logic         sm_hold;
    logic         qn_hold;
    logic         rn_hold;
    logic         bz_hold;

    // Per-run context captured when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hold  <= '0;
            sm_hold <= 1'b0;
            qn_hold <= 1'b0;
            rn_hold <= 1'b0;
            bz_hold <= 1'b0;
        end else if (load) begin
            a_hold  <= a_raw;
            sm_hold <= signed_mode;
            qn_hold <= q_neg;
            rn_hold <= r_neg;
            bz_hold <= b_zero;
        end
    end

    // Result registers and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi   <= '0;
            lo   <= '0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                if (bz_hold) begin
                    lo <= '1;
                    hi <= a_hold;
                end else begin
                    lo <= qn_hold ? (~quot_mag + W'(1)) : quot_mag;
                    hi <= rn_hold ? (~rem_mag + W'(1)) : rem_mag;
                end
            end
        end
    end

    // R7: a zero divisor yields all ones and the dividend.
    a_r7_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && bz_hold) |=> (lo == '1 && hi == a_hold));

    // R6: a nonzero signed remainder carries the dividend's sign.
    a_r6_rem_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sm_hold && !bz_hold && hi != '0) |-> (hi[W-1] == a_hold[W-1]));

    // R9: outputs move only on the publish edge.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> ($stable(hi) && $stable(lo)));

    // R3: done is a single-cycle pulse.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/seq_restoring_divider.sv
// Module: seq_restoring_divider (top)
// Iterative restoring divider, quotient on lo and remainder on hi, start/busy/done.
// Assumes: operands and mode are valid in the cycle start is raised.
module seq_restoring_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    logic         load;
    logic         step;
    logic         finish;
    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;
    logic         q_neg;
    logic         r_neg;
    logic         b_zero;
    logic [W-1:0] quot_mag;
    logic [W-1:0] rem_mag;

    div_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .step   (step),
        .finish (finish),
        .busy   (busy)
    );

    div_operand_prep #(.W(W)) u_prep (
        .a_raw       (dividend),
        .b_raw       (divisor),
        .signed_mode (signed_mode),
        .a_mag       (a_mag),
        .b_mag       (b_mag),
        .q_neg       (q_neg),
        .r_neg       (r_neg),
        .b_zero      (b_zero)
    );

    div_step_core #(.W(W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .step         (step),
        .finish       (finish),
        .dividend_mag (a_mag),
        .divisor_mag  (b_mag),
        .quot_mag     (quot_mag),
        .rem_mag      (rem_mag)
    );

    div_sign_fix #(.W(W)) u_fix (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .finish      (finish),
        .a_raw       (dividend),
        .signed_mode (signed_mode),
        .q_neg       (q_neg),
        .r_neg       (r_neg),
        .b_zero      (b_zero),
        .quot_mag    (quot_mag),
        .rem_mag     (rem_mag),
        .hi          (hi),
        .lo          (lo),
        .done        (done)
    );

    // R2: busy and done never overlap.
    a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/seq_restoring_divider_bench.sv
module seq_restoring_divider_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy;
    logic        done;
    logic [31:0] hi;
    logic [31:0] lo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dones = 0;
    int pushes = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic [31:0] last_hi = '0;
    logic [31:0] last_lo = '0;

    logic [63:0] exp_q[$];
    int          cyc_q[$];
    string       tag_q[$];

    seq_restoring_divider u_seq_restoring_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b, input bit sm);
        longint sa, sb, q, r;
        if (b == 0) return {a, 32'hFFFF_FFFF};
        if (!sm) return {a % b, a / b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Raise start in the current negedge slot, push the expected result.
    task automatic issue_now(input logic [31:0] a, input logic [31:0] b, input bit sm, input string tag);
        start = 1'b1; dividend = a; divisor = b; signed_mode = sm;
        exp_q.push_back(model(a, b, sm));
        cyc_q.push_back(cyc + LATENCY);
        tag_q.push_back(tag);
        pushes++;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input bit sm, input string tag);
        @(negedge clk);
        while (busy) @(negedge clk);
        issue_now(a, b, sm, tag);
        check(busy == 1'b1, "R3 busy after start", {63'b0, busy}, 64'd1);
        wait_empty();
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pop and compare each result as done appears.
    always @(negedge clk) begin
        if (rst_n && done) begin
            dones++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected done actual=%h expected=none", {hi, lo});
            end else begin
                logic [63:0] e;
                int ec;
                string t;
                e = exp_q.pop_front();
                ec = cyc_q.pop_front();
                t = tag_q.pop_front();
                check({hi, lo} == e, t, {hi, lo}, e);
                check(cyc == ec, "R3 latency", 64'(cyc), 64'(ec));
                check(busy == 1'b0, "R3 busy low at done", {63'b0, busy}, 64'd0);
                last_hi = hi; last_lo = lo;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, hi, lo} == '0, "R1 reset state", {busy, done, hi[29:0], lo}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, hi, lo} == '0, "R1 after release", {busy, done, hi[29:0], lo}, 64'd0);

        // R4 unsigned
        run(32'd7, 32'd2, 1'b0, "R4 7/2");
        run(32'd100, 32'd7, 1'b0, "R4 100/7");
        run(32'hFFFF_FFFF, 32'd1, 1'b0, "R4 max/1");
        run(32'd5, 32'd9, 1'b0, "R4 small/large");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 max/max");
        run(32'h8000_0000, 32'd3, 1'b0, "R4 msb/3");
        for (int i = 0; i < 12; i++) run(next_rand(), next_rand() >> (i % 24), 1'b0, "R4 random");

        // R5 and R6 signed
        run(-32'sd7, 32'sd2, 1'b1, "R5 R6 -7/2");
        run(32'sd7, -32'sd2, 1'b1, "R5 R6 7/-2");
        run(-32'sd7, -32'sd2, 1'b1, "R5 R6 -7/-2");
        run(-32'sd6, 32'sd3, 1'b1, "R6 exact zero remainder");
        run(32'h8000_0000, 32'sd7, 1'b1, "R5 most negative/7");
        for (int i = 0; i < 12; i++) run(next_rand(), next_rand() >> (i % 20), 1'b1, "R5 R6 random");

        // R7 zero divisor
        run(32'h0000_1234, 32'd0, 1'b0, "R7 unsigned zero divisor");
        run(32'hFFFF_FFFB, 32'd0, 1'b1, "R7 signed zero divisor");

        // R8 wrap
        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8 wrap");

        // R2 start during busy is ignored
        @(negedge clk);
        issue_now(32'd1000, 32'd9, 1'b0, "R2 run with ignored start");
        repeat (5) @(negedge clk);
        start = 1'b1; dividend = 32'd55; divisor = 32'd4; signed_mode = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_empty();
        repeat (40) @(negedge clk);
        check(dones == pushes, "R2 no extra done", 64'(dones), 64'(pushes));

        // R9 hold while idle and through a new run
        check({hi, lo} == {last_hi, last_lo}, "R9 hold idle", {hi, lo}, {last_hi, last_lo});
        issue_now(32'd81, 32'd8, 1'b0, "R9 next run");
        repeat (10) @(negedge clk);
        check({hi, lo} == model(32'd1000, 32'd9, 1'b0), "R9 hold during run", {hi, lo}, model(32'd1000, 32'd9, 1'b0));
        wait_empty();

        // R10 start in the done cycle
        @(negedge clk);
        issue_now(32'd500, 32'd3, 1'b0, "R10 first");
        while (!done) @(negedge clk);
        issue_now(-32'sd500, 32'sd3, 1'b1, "R10 back-to-back second");
        check(busy == 1'b1, "R10 accepted in done cycle", {63'b0, busy}, 64'd1);
        wait_empty();
        repeat (40) @(negedge clk);
        check(dones == pushes, "R10 done count", 64'(dones), 64'(pushes));

        finish_sim();
    end

endmodule